// File: doc/BRIEF.md
# AES Column Mixing Unit (Mask-Based Doubling)

This unit applies the AES column-mixing transform to a full 128-bit state. It handles all four 32-bit columns in the same cycle. No lookup table is involved.

Each byte is doubled in GF(2^8) in two steps. First, a mask is built from the byte's top bit. Second, the byte is XORed with that mask and rotated left by one, so that the top bit lands in bit 0. Wide XOR layers then combine the doubled bytes with the original bytes to form each output byte.

A state is captured whenever `in_valid` is high. The mixed result appears on `out_state` one cycle later, flagged by `out_valid`.

Top module: `mixcol_mask_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_state` is all zeros.
- R2: Column c (0..3) occupies `in_state[127-32c -: 32]`. Row r (0..3) of that column is the byte at `[127-32c-8r -: 8]`, so row 0 is the most significant byte. The output uses the same layout.
- R3: The doubling of a byte b is defined as follows. The mask is 8'b0000_x7x70x7, where x7 = b[7]. The result is ((b ^ mask) << 1) with bit 0 set to x7. This equals the usual doubling modulo 0x11B. As an example, a column {80,00,00,00} gives {1b,80,80,9b}.
- R4: Output row r of a column equals 2·a[r] ^ 3·a[r+1] ^ a[r+2] ^ a[r+3], with row indices taken mod 4 within that column.
- R5: Each column's output depends only on that column's input bytes. All four columns are transformed in the same cycle.
- R6: `out_valid` in a cycle equals `in_valid` in the previous cycle. The result of a state presented with `in_valid` high appears on `out_state` one cycle later.
- R7: When `in_valid` is low, `out_state` keeps its previous value.
- R8: The input column db 13 53 45 gives 8e 4d a1 bc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input state is valid and is to be captured |
| in_state | input | 128 | State to transform, four columns |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_state | output | 128 | Mixed state |

## Verification
The bench goes after bytes with the top bit set and then with it clear. A wrong mask, or a missing feed of bit 7 into bit 0, corrupts only the doubled terms. That shows up on vectors such as {80,00,00,00} but not on all-equal columns.

It places a single nonzero column among zero columns. A byte-order or column-placement slip then shows up as output leaking into the wrong column or the wrong row.

It also drops `in_valid` with a changed input. A design that captures regardless would alter `out_state`. A design with a missing or extra output register would misalign `out_valid` relative to the data.

// File: rtl/mixcol_mask_unit.sv
module mixcol_mask_unit #(
  parameter int NCOL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [32*NCOL-1:0] in_state,
  output logic               out_valid,
  output logic [32*NCOL-1:0] out_state
);
  localparam int NB = 4 * NCOL;
  localparam int W  = 32 * NCOL;

  logic [7:0]   a  [NB];
  logic [7:0]   dbl[NB];
  logic [W-1:0] mixed;

  function automatic logic [7:0] ref_dbl(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [7:0] msk, flip;
    assign a[k]   = in_state[W-1-8*k -: 8];
    assign msk    = {4'b0000, a[k][7], a[k][7], 1'b0, a[k][7]};
    assign flip   = a[k] ^ msk;
    assign dbl[k] = {flip[6:0], a[k][7]};
    always_comb
      assert_xtime_R3: assert (dbl[k] == ref_dbl(a[k]));
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int B0 = 4*c + r;
      localparam int B1 = 4*c + (r+1)%4;
      localparam int B2 = 4*c + (r+2)%4;
      localparam int B3 = 4*c + (r+3)%4;
      assign mixed[W-1-8*B0 -: 8] = dbl[B0] ^ dbl[B1] ^ a[B1] ^ a[B2] ^ a[B3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_state <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_state <= mixed;
    end
  end

  assert_valid_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_state));
  assert_row0_col0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_state[W-1 -: 8] ==
      (ref_dbl($past(in_state[W-1 -: 8])) ^ ref_dbl($past(in_state[W-9 -: 8])) ^
       $past(in_state[W-9 -: 8]) ^ $past(in_state[W-17 -: 8]) ^ $past(in_state[W-25 -: 8])));
endmodule

// File: tb/mixcol_mask_unit_tb.sv
module mixcol_mask_unit_tb;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [127:0] in_state = '0;
  logic out_valid;
  logic [127:0] out_state;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mixcol_mask_unit u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_state(in_state), .out_valid(out_valid), .out_state(out_state));

  localparam logic [255:0] VEC [5] = '{
    {128'hdb135345_f20a225c_01010101_c6c6c6c6, 128'h8e4da1bc_9fdc589d_01010101_c6c6c6c6},
    {128'hd4d4d4d5_2d26314c_80000000_00000000, 128'hd5d5d7d6_4d7ebdf8_1b80809b_00000000},
    {128'hd4bf5d30_e0b452ae_b84111f1_1e2798e5, 128'h046681e5_e0cb199a_48f8d37a_2806264c},
    {128'hffffffff_00000000_01000000_00000080, 128'hffffffff_00000000_02010103_80809b1b},
    {128'h00000000_00000000_00000000_00000000, 128'h00000000_00000000_00000000_00000000}
  };

  function automatic logic [7:0] m2(input logic [7:0] v);
    logic [7:0] t = v;
    for (int i = 0; i < 1; i++) t = v[7] ? ((v << 1) ^ 8'h1b) : (v << 1);
    return t;
  endfunction

  function automatic logic [127:0] model(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] b0, b1, b2, b3;
        b0 = s[127-32*c-8*r -: 8];
        b1 = s[127-32*c-8*((r+1)%4) -: 8];
        b2 = s[127-32*c-8*((r+2)%4) -: 8];
        b3 = s[127-32*c-8*((r+3)%4) -: 8];
        o[127-32*c-8*r -: 8] = m2(b0) ^ m2(b1) ^ b1 ^ b2 ^ b3;
      end
    return o;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] s);
    @(negedge clk);
    in_valid = 1;
    in_state = s;
    @(negedge clk);
  endtask

  initial begin
    logic [127:0] lfsr, held;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {127'd0, out_valid}, 128'd0);
    chk("R1 out_state", out_state, 128'd0);
    rst_n = 1;

    for (int i = 0; i < 5; i++) begin
      apply(VEC[i][255:128]);
      chk("R2/R3/R4/R8 vector", out_state, VEC[i][127:0]);
      chk("R6 out_valid", {127'd0, out_valid}, 128'd1);
    end

    apply(128'hdb135345_00000000_00000000_00000000);
    chk("R8 column db135345", out_state, 128'h8e4da1bc_00000000_00000000_00000000);

    apply(128'h00000000_00000000_d4bf5d30_00000000);
    chk("R5 single column", out_state, 128'h00000000_00000000_046681e5_00000000);

    apply(128'h00000000_00000000_00000000_80000000);
    chk("R3 top bit set", out_state, 128'h00000000_00000000_00000000_1b80809b);

    lfsr = 128'h0123456789abcdef_fedcba9876543210;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[126:0], lfsr[127] ^ lfsr[125] ^ lfsr[100] ^ lfsr[98]} ^ (lfsr >> 7);
      apply(lfsr);
      chk("R4 model", out_state, model(lfsr));
    end

    held = out_state;
    @(negedge clk);
    in_valid = 0;
    in_state = 128'hdeadbeef_cafef00d_01234567_89abcdef;
    @(negedge clk);
    chk("R6 idle out_valid", {127'd0, out_valid}, 128'd0);
    chk("R7 hold", out_state, held);
    @(negedge clk);
    chk("R7 hold again", out_state, held);

    in_valid = 1;
    @(negedge clk);
    chk("R6 resume", out_state, model(128'hdeadbeef_cafef00d_01234567_89abcdef));
    in_valid = 0;

    rst_n = 0;
    @(negedge clk);
    chk("R1 reset again", out_state, 128'd0);
    chk("R1 valid again", {127'd0, out_valid}, 128'd0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule